// File: doc/BRIEF.md
# Scalar Bit-Scan and Quad-Mask Unit

This unit evaluates one scalar operation per clock on 64-bit or 32-bit operands. It expands a lane mask to whole groups of four bits, packs a mask into one bit per four-bit group, counts clear bits, and finds the lowest clear bit, the lowest set bit, the distance of the highest set bit from the top, and the length of the leading run of sign-equal bits. It also takes the median of three operands, signed or unsigned. Every scan returns -1 when it finds nothing.

A wide-select input picks the operand width. In narrow mode the upper 32 bits of every operand are ignored, and the registered result is a signed 32-bit value sign-extended to 64 bits. The operation is selected by a 4-bit opcode. The result register sits behind the combinational datapath and has a synchronous active-low reset.

Top module: `sbq_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res_o` becomes 0. Otherwise `res_o` shows the result of the inputs sampled at the previous rising edge.
- R2: Opcode 0x0 (group expand) sets all four bits of output group q, bits [4q+3:4q], to 1 when any bit of input group q is 1. Otherwise that group is 0.
- R3: Opcode 0x1 (group pack) sets output bit q when input group q is non-zero. All higher bits are 0, so a 64-bit operand gives a 16-bit result.
- R4: Opcode 0x2 returns the operand width minus the number of set bits.
- R5: Opcode 0x3 returns the index of the lowest clear bit. It returns -1 when every bit is set.
- R6: Opcode 0x4 returns the index of the lowest set bit. It returns -1 for a zero operand.
- R7: Opcode 0x5 returns width-1-h, where h is the index of the highest set bit. It returns -1 for a zero operand.
- R8: Opcode 0x6 returns how many bits, counted down from the top bit and including it, equal the top bit. It returns -1 when the operand is zero or all ones.
- R9: Opcode 0x8 returns the unsigned median of a, b and c, and opcode 0x9 the two's-complement signed median. In both cases the median is max(min(a,b), min(max(a,b),c)).
- R10: With `wide_i` low, bits [63:32] of every operand have no effect, and `res_o[63:32]` repeats `res_o[31]`.
- R11: Opcodes 0x7 and 0xA to 0xF produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| a_i | input | 64 | Operand a (the only operand for the scan and mask operations) |
| b_i | input | 64 | Operand b (median only) |
| c_i | input | 64 | Operand c (median only) |
| res_o | output | 64 | Registered result |

## Verification
Every result appears exactly one rising edge after its inputs are sampled, whatever the opcode, because the datapath has no other stage. The bench drives inputs on a falling edge and reads `res_o` on the following falling edge. At that point exactly one rising edge has captured the stimulus. The reset value is read the same way, one edge after `rst_n` is driven low.

// File: rtl/sbq_pkg.sv
// Shared opcode encoding for the scalar bit-scan and quad-mask unit.
// Assumes a 4-bit opcode; bit 3 set with bits 2:1 clear marks a median.
package sbq_pkg;
    typedef enum logic [3:0] {
        OP_GRP_EXPAND = 4'h0,
        OP_GRP_PACK   = 4'h1,
        OP_ZERO_COUNT = 4'h2,
        OP_LOW_CLEAR  = 4'h3,
        OP_LOW_SET    = 4'h4,
        OP_HIGH_SET   = 4'h5,
        OP_SIGN_RUN   = 4'h6,
        OP_MED_UNS    = 4'h8,
        OP_MED_SGN    = 4'h9
    } sbq_op_e;
endpackage

// File: rtl/sbq_scan.sv
// Bit counting and scanning over a W-bit operand, or its low NW bits.
// Assumes the caller sign-extends narrow results; every "not found" case
// is returned as all ones (-1). Purely combinational.
module sbq_scan #(
    parameter int W  = 64,
    parameter int NW = 32
) (
    input  logic [W-1:0] a_i,
    input  logic         wide_i,
    output logic [W-1:0] zcnt_o,
    output logic [W-1:0] low_clear_o,
    output logic [W-1:0] low_set_o,
    output logic [W-1:0] high_set_o,
    output logic [W-1:0] sign_run_o
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  live, ones, zeros, run_src;
    logic [CW-1:0] wcnt, pop, lo1, lo0, hi1, hir;
    logic          f1, f0, fh, fr, sgn;

    // Operand views restricted to the active width
    always_comb begin
        live    = wide_i ? '1 : {{(W-NW){1'b0}}, {NW{1'b1}}};
        ones    = a_i & live;
        zeros   = ~a_i & live;
        sgn     = wide_i ? a_i[W-1] : a_i[NW-1];
        run_src = sgn ? zeros : ones;
        wcnt    = wide_i ? CW'(W) : CW'(NW);
    end

    // Population count and the four priority searches
    always_comb begin
        pop = '0;
        lo1 = '0; f1 = 1'b0;
        lo0 = '0; f0 = 1'b0;
        hi1 = '0; fh = 1'b0;
        hir = '0; fr = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            pop = pop + CW'(ones[i]);
            if (ones[i])  begin lo1 = CW'(i); f1 = 1'b1; end
            if (zeros[i]) begin lo0 = CW'(i); f0 = 1'b1; end
        end
        for (int i = 0; i < W; i++) begin
            if (ones[i])    begin hi1 = CW'(i); fh = 1'b1; end
            if (run_src[i]) begin hir = CW'(i); fr = 1'b1; end
        end
    end

    // Result formatting with -1 for empty searches
    always_comb begin
        zcnt_o      = {{(W-CW){1'b0}}, wcnt - pop};
        low_set_o   = f1 ? {{(W-CW){1'b0}}, lo1} : '1;
        low_clear_o = f0 ? {{(W-CW){1'b0}}, lo0} : '1;
        high_set_o  = fh ? {{(W-CW){1'b0}}, wcnt - CW'(1) - hi1} : '1;
        sign_run_o  = fr ? {{(W-CW){1'b0}}, wcnt - CW'(1) - hir} : '1;
    end
endmodule

// File: rtl/sbq_quad.sv
// Group-of-Q mask expansion and packing. Assumes W is a multiple of Q
// and that unused upper operand bits are already cleared by the caller.
module sbq_quad #(
    parameter int W = 64,
    parameter int Q = 4
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] expand_o,
    output logic [W-1:0] pack_o
);
    localparam int NG = W / Q;

    logic [NG-1:0] any_set;

    // One OR-reduction per group drives both results
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign any_set[g]          = |a_i[g*Q +: Q];
        assign expand_o[g*Q +: Q]  = {Q{any_set[g]}};
    end

    // Packed flags sit in the low bits, the rest is clear
    assign pack_o = {{(W-NG){1'b0}}, any_set};
endmodule

// File: rtl/sbq_median.sv
// Median of three, signed or unsigned. Narrow operands are extended
// from bit NW-1 according to the signedness, so one W-bit comparator
// serves both widths. Purely combinational.
module sbq_median #(
    parameter int W  = 64,
    parameter int NW = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic         wide_i,
    input  logic         signed_i,
    output logic [W-1:0] med_o
);
    logic [W-1:0] xa, xb, xc, lo_ab, hi_ab, lo_hc;

    function automatic logic [W-1:0] extend(input logic [W-1:0] v,
                                            input logic wide, input logic sg);
        if (wide) return v;
        return {{(W-NW){sg & v[NW-1]}}, v[NW-1:0]};
    endfunction

    // Signed compare done as unsigned with the top bit flipped
    function automatic logic less(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic sg);
        return {x[W-1] ^ sg, x[W-2:0]} < {y[W-1] ^ sg, y[W-2:0]};
    endfunction

    // Extension, then max(min(a,b), min(max(a,b),c))
    always_comb begin
        xa    = extend(a_i, wide_i, signed_i);
        xb    = extend(b_i, wide_i, signed_i);
        xc    = extend(c_i, wide_i, signed_i);
        lo_ab = less(xa, xb, signed_i) ? xa : xb;
        hi_ab = less(xa, xb, signed_i) ? xb : xa;
        lo_hc = less(hi_ab, xc, signed_i) ? hi_ab : xc;
        med_o = less(lo_ab, lo_hc, signed_i) ? lo_hc : lo_ab;
    end
endmodule

// File: rtl/sbq_unit.sv
// Scalar bit-scan and quad-mask unit: selects one of the scan, mask or
// median results by opcode, narrows it to a sign-extended 32-bit value
// when wide_i is low, and registers it. Assumes one operation per cycle.
module sbq_unit
    import sbq_pkg::*;
#(
    parameter int W      = 64,
    parameter int NW     = 32,
    parameter int QUAD_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic         wide_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] res_o
);
    localparam int NG = W / QUAD_W;

    logic [W-1:0] a_live, zcnt, lclr, lset, hset, srun, qexp, qpack, med;
    logic [W-1:0] sel, narrowed;
    sbq_op_e      op;

    assign op     = sbq_op_e'(op_i);
    assign a_live = wide_i ? a_i : {{(W-NW){1'b0}}, a_i[NW-1:0]};

    sbq_scan #(.W(W), .NW(NW)) u_scan (
        .a_i(a_i), .wide_i(wide_i), .zcnt_o(zcnt), .low_clear_o(lclr),
        .low_set_o(lset), .high_set_o(hset), .sign_run_o(srun)
    );

    sbq_quad #(.W(W), .Q(QUAD_W)) u_quad (
        .a_i(a_live), .expand_o(qexp), .pack_o(qpack)
    );

    sbq_median #(.W(W), .NW(NW)) u_med (
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .wide_i(wide_i),
        .signed_i(op_i[0]), .med_o(med)
    );

    // Opcode selection of the result
    always_comb begin
        case (op)
            OP_GRP_EXPAND: sel = qexp;
            OP_GRP_PACK:   sel = qpack;
            OP_ZERO_COUNT: sel = zcnt;
            OP_LOW_CLEAR:  sel = lclr;
            OP_LOW_SET:    sel = lset;
            OP_HIGH_SET:   sel = hset;
            OP_SIGN_RUN:   sel = srun;
            OP_MED_UNS,
            OP_MED_SGN:    sel = med;
            default:       sel = '0;
        endcase
    end

    // Narrow-mode sign extension from bit NW-1
    assign narrowed = wide_i ? sel : {{(W-NW){sel[NW-1]}}, sel[NW-1:0]};

    // Result register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) res_o <= '0;
        else        res_o <= narrowed;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> res_o == '0);

    // R10
    narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> res_o[W-1:NW] == {(W-NW){res_o[NW-1]}});

    // R3
    pack_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'h1) && wide_i |=> res_o[W-1:NG] == '0);

    // R9
    median_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:1] == 3'b100) && wide_i |=>
        (res_o == $past(a_i)) || (res_o == $past(b_i)) || (res_o == $past(c_i)));

    // R5 R6 R7 R8
    scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'h3) && (op_i <= 4'h6) |=>
        ($signed(res_o) >= -1) && ($signed(res_o) < W));

    // R4
    zero_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'h2) |=> res_o <= W);
endmodule

// File: tb/sbq_unit_test.sv
`timescale 1ns/1ps
module sbq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'h0;
    logic        wide = 1'b1;
    logic [63:0] a = '0, b = '0, c = '0;
    logic [63:0] res;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    sbq_unit uut (.clk(clk), .rst_n(rst_n), .op_i(op), .wide_i(wide),
                  .a_i(a), .b_i(b), .c_i(c), .res_o(res));

    function automatic logic le(logic [63:0] x, logic [63:0] y, logic sg);
        return sg ? ($signed(x) <= $signed(y)) : (x <= y);
    endfunction

    function automatic logic [63:0] model(logic [3:0] o, logic w,
                                          logic [63:0] x, logic [63:0] y, logic [63:0] z);
        int n = w ? 64 : 32;
        logic [63:0] r = '0;
        int cnt;
        logic run;
        logic sg = o[0];
        case (o)
            4'h0: for (int q = 0; q < n/4; q++) if (x[4*q +: 4] != 0) r[4*q +: 4] = 4'hF;
            4'h1: for (int q = 0; q < n/4; q++) r[q] = (x[4*q +: 4] != 0);
            4'h2: begin cnt = 0; for (int i = 0; i < n; i++) if (!x[i]) cnt++; r = 64'(cnt); end
            4'h3: begin r = '1; for (int i = n-1; i >= 0; i--) if (!x[i]) r = 64'(i); end
            4'h4: begin r = '1; for (int i = n-1; i >= 0; i--) if (x[i]) r = 64'(i); end
            4'h5: begin r = '1; for (int i = 0; i < n; i++) if (x[i]) r = 64'(n-1-i); end
            4'h6: begin
                cnt = 0; run = 1'b1;
                for (int i = n-1; i >= 0; i--)
                    if (run && x[i] == x[n-1]) cnt++; else run = 1'b0;
                r = (cnt == n) ? '1 : 64'(cnt);
            end
            4'h8, 4'h9: begin
                if (!w) begin
                    x = {{32{sg & x[31]}}, x[31:0]};
                    y = {{32{sg & y[31]}}, y[31:0]};
                    z = {{32{sg & z[31]}}, z[31:0]};
                end
                if ((le(x,y,sg) && le(y,z,sg)) || (le(z,y,sg) && le(y,x,sg))) r = y;
                else if ((le(y,x,sg) && le(x,z,sg)) || (le(z,x,sg) && le(x,y,sg))) r = x;
                else r = z;
            end
            default: r = '0;
        endcase
        if (!w) r = {{32{r[31]}}, r[31:0]};
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'h0: return "R2";  4'h1: return "R3";  4'h2: return "R4";
            4'h3: return "R5";  4'h4: return "R6";  4'h5: return "R7";
            4'h6: return "R8";  4'h8, 4'h9: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] rnd64(int shape);
        logic [63:0] v = {$urandom, $urandom};
        case (shape)
            1: v = v & {$urandom, $urandom} & {$urandom, $urandom};
            2: v = v | {$urandom, $urandom} | {$urandom, $urandom};
            3: begin
                v = v >> $urandom_range(0, 63);
                if ($urandom_range(0, 1) == 1) v = ~v;
            end
            default: ;
        endcase
        return v;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive on a falling edge, read one rising edge later
    task automatic run(string req, logic [3:0] o, logic w,
                       logic [63:0] x, logic [63:0] y, logic [63:0] z);
        @(negedge clk);
        op = o; wide = w; a = x; b = y; c = z;
        @(negedge clk);
        check(req, res, model(o, w, x, y, z));
    endtask

    initial begin
        #(8 * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset clears the register even with live inputs
        op = 4'h0; wide = 1'b1; a = '1;
        @(negedge clk); @(negedge clk);
        check("R1", res, 64'h0);
        rst_n = 1'b1;
        // R1: result due one edge after the stimulus
        run("R1", 4'h4, 1'b1, 64'h100, 0, 0);
        // R2 / R3 directed
        run("R2", 4'h0, 1'b1, 64'h8000_0000_0001_0020, 0, 0);
        run("R3", 4'h1, 1'b1, 64'h8000_0000_0001_0020, 0, 0);
        run("R3", 4'h1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        // R4 boundaries
        run("R4", 4'h2, 1'b1, 64'h0, 0, 0);
        run("R4", 4'h2, 1'b1, '1, 0, 0);
        // R5 / R6 / R7 -1 cases and edges
        run("R5", 4'h3, 1'b1, '1, 0, 0);
        run("R5", 4'h3, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0);
        run("R6", 4'h4, 1'b1, 64'h0, 0, 0);
        run("R6", 4'h4, 1'b1, 64'h8000_0000_0000_0000, 0, 0);
        run("R7", 4'h5, 1'b1, 64'h0, 0, 0);
        run("R7", 4'h5, 1'b1, 64'h1, 0, 0);
        // R8 sign runs
        run("R8", 4'h6, 1'b1, 64'h0, 0, 0);
        run("R8", 4'h6, 1'b1, '1, 0, 0);
        run("R8", 4'h6, 1'b1, 64'hFFF0_0000_0000_0000, 0, 0);
        run("R8", 4'h6, 1'b0, 64'h0000_0000_0000_00FF, 0, 0);
        // R9 signed vs unsigned and ties
        run("R9", 4'h8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 64'h3);
        run("R9", 4'h9, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5, 64'h3);
        run("R9", 4'h9, 1'b1, 64'h7, 64'h7, 64'h2);
        run("R9", 4'h9, 1'b0, 64'h0000_0000_8000_0000, 64'h1, 64'h0000_0000_FFFF_FFFE);
        run("R9", 4'h8, 1'b0, 64'h0000_0000_8000_0000, 64'h1, 64'h0000_0000_FFFF_FFFE);
        // R10 upper garbage ignored in narrow mode
        run("R10", 4'h4, 1'b0, 64'hFFFF_FFFF_0000_0000, 0, 0);
        run("R10", 4'h2, 1'b0, 64'hFFFF_FFFF_0000_000F, 0, 0);
        run("R10", 4'h0, 1'b0, 64'h1234_5678_1000_0000, 0, 0);
        run("R10", 4'h5, 1'b0, 64'hABCD_0000_0000_0001, 0, 0);
        // R11 unused codes
        run("R11", 4'h7, 1'b1, '1, '1, '1);
        run("R11", 4'hF, 1'b0, '1, '1, '1);
        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            int pick = $urandom_range(0, 10);
            logic [3:0] o = (pick <= 6) ? 4'(pick) : (pick == 7) ? 4'h8 :
                            (pick == 8) ? 4'h9 : (pick == 9) ? 4'h7 : 4'hC;
            logic w = ($urandom_range(0, 2) != 0);
            run(w ? tag_of(o) : {tag_of(o), "/R10"}, o, w,
                rnd64($urandom_range(0, 3)), rnd64($urandom_range(0, 3)),
                rnd64($urandom_range(0, 3)));
        end
        // R1: reset in mid-stream clears the result again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); check("R1", res, 64'h0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule